// File: doc/BRIEF.md
# SD Single-Block Data Transfer Engine

This engine carries one data block of 512 bytes across an SPI link to a memory card. It runs after a separate command stage has issued the read-block or write-block command. It includes its own byte-serial SPI shifter in mode 0. The shifter holds the serial clock low when idle, shifts out MSB first, and samples on the rising edge. The engine asserts chip select for the whole data phase and reads or fills a local byte buffer through a synchronous single-port interface, in address order.

A read sends filler bytes and waits for the start token. It then stores the block and throws the two checksum bytes away. A write sends the start token, the buffer contents and two dummy checksum bytes. It then decodes the card's data-response byte and, if the card accepted the block, waits out the busy period. Limits programmed on two inputs bound both waits. The block finishes every transfer the same way. It raises chip select, clocks one more filler byte and pulses `done`. A small side path turns a block number into the 32-bit command argument according to the card's addressing mode.

Top module: `sd_blk_xfer`

## Requirements
- R1: Reset state: after reset and before any start, `cs_n`=1, `done`=0, `err`=0, `wr_status`=0, `sclk`=0 and `mosi`=1.
- R2: `cmd_arg` equals `blk_num` when `blk_mode`=1 (block-addressed card). When `blk_mode`=0 (byte-addressed card) it equals `blk_num` multiplied by 512, truncated to 32 bits.
- R3: A read (`dir_wr`=0) sends only 0xFF bytes. It skips any received byte other than 0xFE. It writes the 512 bytes that follow the first 0xFE into buffer addresses 0 to 511 in arrival order.
- R4: After the 512th data byte of a read, exactly two more bytes are clocked and not stored. Chip select then rises, so a read whose token follows g other bytes keeps `cs_n` low for g+515 bytes.
- R5: `hunt_limit` must be at least 1. If the start token has not been preceded by fewer than `hunt_limit` other bytes, the read stops after `hunt_limit` bytes with `err`=1 and `wr_status`=0, and the buffer is left unchanged.
- R6: A write (`dir_wr`=1) sends 0xFE, then buffer bytes 0 to 511 in order, then two 0xFF bytes, then 0xFF while it receives the response byte.
- R7: The response byte is accepted when its low five bits are 0b00101. `wr_status` takes bits [3:1] of that byte (2 = accepted, 5 = checksum error, 6 = write error). A rejected byte sets `err`=1 and releases chip select at once, with no busy wait (516 bytes with `cs_n` low).
- R8: After an accepted response the engine keeps clocking 0xFF while it receives 0x00. The first nonzero byte ends the wait, so b busy bytes give 517+b bytes with `cs_n` low.
- R9: `busy_limit` must be at least 1. If `busy_limit` zero bytes arrive in a row, the engine stops with `err`=1 and `wr_status`=2 after 516+`busy_limit` bytes with `cs_n` low.
- R10: Every transfer ends by raising `cs_n` and clocking exactly one 0xFF byte with `cs_n` high. `done` then goes high for exactly one cycle while `cs_n` is high. `err` and `wr_status` hold until the next start.
- R11: A `start` pulse during a transfer, even with the other direction, is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| dir_wr | input | 1 | 1 = write to card, 0 = read from card |
| blk_num | input | ARG_W | Block number for the argument conversion |
| blk_mode | input | 1 | 1 = block-addressed card, 0 = byte-addressed |
| hunt_limit | input | LIM_W | Byte limit for the start-token search |
| busy_limit | input | LIM_W | Byte limit for the busy wait |
| cmd_arg | output | ARG_W | Command argument for the block number |
| cs_n | output | 1 | Card chip select, active low |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_we | output | 1 | Buffer write strobe (read transfers) |
| buf_wdata | output | 8 | Byte written to the buffer |
| buf_rdata | input | 8 | Buffer read data, one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transfer failed (timeout or rejected block) |
| wr_status | output | 3 | Status field of the last write-response byte |

## Verification
The hardest conditions to reach are the two write endings that depend on what the card says after the block: a rejected response byte and a busy period that runs into its limit. Both occur only after more than five hundred bytes have been exchanged. The bench's card model serialises a scripted answer for every byte index while chip select is low. A table row chooses the response byte and the length of the zero run, so each ending and the boundary one byte short of each limit can be set up directly. The model also counts the bytes seen with chip select low and high, which shows whether the checksum bytes, the busy wait and the trailing filler byte were clocked exactly as required.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;

  localparam logic [7:0] TOKEN_START = 8'hFE;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [4:0] RESP_ACCEPT = 5'b00101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_HUNT,
    ST_RD_DATA,
    ST_RD_CRC,
    ST_WR_TOKEN,
    ST_WR_FETCH,
    ST_WR_DATA,
    ST_WR_CRC,
    ST_WR_RESP,
    ST_WR_BUSY,
    ST_RELEASE,
    ST_FINISH
  } xfer_state_e;

  // Chip select is held low in every state of the data phase.
  function automatic logic card_selected(xfer_state_e s);
    return !(s inside {ST_IDLE, ST_RELEASE, ST_FINISH});
  endfunction

  // States that exchange one byte over the serial link.
  function automatic logic byte_state(xfer_state_e s);
    return !(s inside {ST_IDLE, ST_WR_FETCH, ST_FINISH});
  endfunction

endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sd_byte_shifter.sv
module sd_byte_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             sclk_q, sclk_n;
  logic             mosi_q, mosi_n;
  logic [7:0]       tx_q, tx_n;
  logic [7:0]       rx_q, rx_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [2:0]       bit_q, bit_n;

  always_comb begin
    busy_n = busy_q;
    sclk_n = sclk_q;
    mosi_n = mosi_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    div_n  = div_q;
    bit_n  = bit_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        tx_n   = tx_byte;
        mosi_n = tx_byte[7];
        sclk_n = 1'b0;
        div_n  = '0;
        bit_n  = '0;
      end
    end else if (div_q == DIV_LAST) begin
      div_n = '0;
      if (!sclk_q) begin
        // rising edge: capture the card's bit
        sclk_n = 1'b1;
        rx_n   = {rx_q[6:0], miso};
      end else begin
        // falling edge: present the next bit or finish
        sclk_n = 1'b0;
        if (bit_q == 3'd7) begin
          busy_n = 1'b0;
          done_n = 1'b1;
          mosi_n = 1'b1;
        end else begin
          bit_n  = bit_q + 3'd1;
          tx_n   = {tx_q[6:0], 1'b0};
          mosi_n = tx_q[6];
        end
      end
    end else begin
      div_n = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      sclk_q <= sclk_n;
      mosi_q <= mosi_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      div_q  <= div_n;
      bit_q  <= bit_n;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

endmodule

// File: rtl/sd_blk_arg.sv
module sd_blk_arg #(
  parameter int ARG_W     = 32,
  parameter int BLK_BYTES = 512
) (
  input  logic [ARG_W-1:0] blk_num,
  input  logic             blk_mode,
  output logic [ARG_W-1:0] cmd_arg
);

  localparam int SHIFT = $clog2(BLK_BYTES);

  logic [ARG_W-1:0] byte_addr;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign byte_addr = blk_num;
    end else begin : g_shift
      assign byte_addr = {blk_num[ARG_W-SHIFT-1:0], {SHIFT{1'b0}}};
    end
  endgenerate

  assign cmd_arg = blk_mode ? blk_num : byte_addr;

endmodule

// File: rtl/sd_blk_ctrl.sv
module sd_blk_ctrl
  import sd_blk_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CRC_BYTES = 2,
  parameter int LIM_W     = 16,
  parameter int ADDR_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic [LIM_W-1:0]  hunt_limit,
  input  logic [LIM_W-1:0]  busy_limit,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic              cs_n,
  output logic              done,
  output logic              err,
  output logic [2:0]        wr_status
);

  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(BLK_BYTES - 1);
  localparam logic [ADDR_W-1:0] CRC_LAST = ADDR_W'(CRC_BYTES - 1);
  localparam logic [LIM_W-1:0]  LIM_ONE  = LIM_W'(1);

  xfer_state_e       st_q, st_n;
  logic [ADDR_W-1:0] idx_q, idx_n;
  logic [LIM_W-1:0]  wc_q, wc_n;
  logic              err_q, err_n;
  logic [2:0]        stat_q, stat_n;
  logic              lnch_q, lnch_n;
  logic              cs_q;
  logic              launch;

  assign launch = byte_state(st_q) && !lnch_q && !sh_busy;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    wc_n   = wc_q;
    err_n  = err_q;
    stat_n = stat_q;
    lnch_n = lnch_q;
    if (launch)  lnch_n = 1'b1;
    if (sh_done) lnch_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          idx_n  = '0;
          wc_n   = '0;
          err_n  = 1'b0;
          stat_n = '0;
          lnch_n = 1'b0;
          st_n   = dir_wr ? ST_WR_TOKEN : ST_RD_HUNT;
        end
      end
      ST_RD_HUNT: begin
        if (sh_done) begin
          if (sh_rx == TOKEN_START) begin
            idx_n = '0;
            st_n  = ST_RD_DATA;
          end else if (wc_q == hunt_limit - LIM_ONE) begin
            err_n = 1'b1;
            st_n  = ST_RELEASE;
          end else begin
            wc_n = wc_q + LIM_ONE;
          end
        end
      end
      ST_RD_DATA: begin
        if (sh_done) begin
          if (idx_q == IDX_LAST) begin
            idx_n = '0;
            st_n  = ST_RD_CRC;
          end else begin
            idx_n = idx_q + ADDR_W'(1);
          end
        end
      end
      ST_RD_CRC: begin
        if (sh_done) begin
          if (idx_q == CRC_LAST) begin
            idx_n = '0;
            st_n  = ST_RELEASE;
          end else begin
            idx_n = idx_q + ADDR_W'(1);
          end
        end
      end
      ST_WR_TOKEN: begin
        if (sh_done) begin
          idx_n = '0;
          st_n  = ST_WR_FETCH;
        end
      end
      ST_WR_FETCH: begin
        st_n = ST_WR_DATA;
      end
      ST_WR_DATA: begin
        if (sh_done) begin
          if (idx_q == IDX_LAST) begin
            idx_n = '0;
            st_n  = ST_WR_CRC;
          end else begin
            idx_n = idx_q + ADDR_W'(1);
            st_n  = ST_WR_FETCH;
          end
        end
      end
      ST_WR_CRC: begin
        if (sh_done) begin
          if (idx_q == CRC_LAST) begin
            idx_n = '0;
            st_n  = ST_WR_RESP;
          end else begin
            idx_n = idx_q + ADDR_W'(1);
          end
        end
      end
      ST_WR_RESP: begin
        if (sh_done) begin
          stat_n = sh_rx[3:1];
          if (sh_rx[4:0] == RESP_ACCEPT) begin
            wc_n = '0;
            st_n = ST_WR_BUSY;
          end else begin
            err_n = 1'b1;
            st_n  = ST_RELEASE;
          end
        end
      end
      ST_WR_BUSY: begin
        if (sh_done) begin
          if (sh_rx != 8'h00) begin
            st_n = ST_RELEASE;
          end else if (wc_q == busy_limit - LIM_ONE) begin
            err_n = 1'b1;
            st_n  = ST_RELEASE;
          end else begin
            wc_n = wc_q + LIM_ONE;
          end
        end
      end
      ST_RELEASE: begin
        if (sh_done) st_n = ST_FINISH;
      end
      ST_FINISH: begin
        st_n = ST_IDLE;
      end
      default: begin
        st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      wc_q   <= '0;
      err_q  <= 1'b0;
      stat_q <= '0;
      lnch_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      wc_q   <= wc_n;
      err_q  <= err_n;
      stat_q <= stat_n;
      lnch_q <= lnch_n;
      cs_q   <= !card_selected(st_n);
    end
  end

  always_comb begin
    unique case (st_q)
      ST_WR_TOKEN: sh_tx = TOKEN_START;
      ST_WR_DATA:  sh_tx = buf_rdata;
      default:     sh_tx = FILL_BYTE;
    endcase
  end

  assign sh_start  = launch;
  assign buf_addr  = idx_q;
  assign buf_we    = (st_q == ST_RD_DATA) && sh_done;
  assign buf_wdata = sh_rx;
  assign cs_n      = cs_q;
  assign done      = (st_q == ST_FINISH);
  assign err       = err_q;
  assign wr_status = stat_q;

endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer #(
  parameter int BLK_BYTES = 512,
  parameter int HALF_DIV  = 4,
  parameter int LIM_W     = 16,
  parameter int ARG_W     = 32,
  parameter int CRC_BYTES = 2,
  parameter int ADDR_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic [ARG_W-1:0]  blk_num,
  input  logic              blk_mode,
  input  logic [LIM_W-1:0]  hunt_limit,
  input  logic [LIM_W-1:0]  busy_limit,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic              done,
  output logic              err,
  output logic [2:0]        wr_status
);

  logic       rst_sync_n;
  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_busy;
  logic       sh_done;
  logic [7:0] sh_rx;

  sd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sd_blk_arg #(
    .ARG_W     (ARG_W),
    .BLK_BYTES (BLK_BYTES)
  ) u_arg (
    .blk_num  (blk_num),
    .blk_mode (blk_mode),
    .cmd_arg  (cmd_arg)
  );

  sd_byte_shifter #(
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (sclk),
    .mosi    (mosi),
    .miso    (miso)
  );

  sd_blk_ctrl #(
    .BLK_BYTES (BLK_BYTES),
    .CRC_BYTES (CRC_BYTES),
    .LIM_W     (LIM_W),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .dir_wr     (dir_wr),
    .hunt_limit (hunt_limit),
    .busy_limit (busy_limit),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .sh_busy    (sh_busy),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx),
    .buf_addr   (buf_addr),
    .buf_we     (buf_we),
    .buf_wdata  (buf_wdata),
    .buf_rdata  (buf_rdata),
    .cs_n       (cs_n),
    .done       (done),
    .err        (err),
    .wr_status  (wr_status)
  );

endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk #(
  parameter int ARG_W     = 32,
  parameter int BLK_BYTES = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             blk_mode,
  input logic [ARG_W-1:0] cmd_arg,
  input logic             cs_n,
  input logic             done,
  input logic             err,
  input logic [2:0]       wr_status,
  input logic             buf_we
);

  localparam int SHIFT = $clog2(BLK_BYTES);

  AST_ARG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_mode |-> (cmd_arg[SHIFT-1:0] == '0)); // R2

  AST_STORE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !cs_n); // R3

  AST_OK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (wr_status == 3'd0 || wr_status == 3'd2)); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_SELECT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start)); // R11

endmodule

bind sd_blk_xfer sd_blk_xfer_chk #(
  .ARG_W     (ARG_W),
  .BLK_BYTES (BLK_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .blk_mode  (blk_mode),
  .cmd_arg   (cmd_arg),
  .cs_n      (cs_n),
  .done      (done),
  .err       (err),
  .wr_status (wr_status),
  .buf_we    (buf_we)
);

// File: tb/tb_sd_blk_xfer.sv
module tb_sd_blk_xfer;

  localparam int BLK = 512;
  localparam int LW  = 16;
  localparam int AW  = 32;
  localparam int CAPN = 1100;

  // {dir, gap_or_busy, token, hunt_lim, busy_lim, seed, exp_err, exp_stat}
  localparam logic [44:0] VECS [8] = '{
    {1'b0, 8'd0, 8'h00, 8'd4, 8'd1, 8'd11, 1'b0, 3'd0},
    {1'b0, 8'd3, 8'h00, 8'd4, 8'd1, 8'd5,  1'b0, 3'd0},
    {1'b0, 8'd4, 8'h00, 8'd4, 8'd1, 8'd9,  1'b1, 3'd0},
    {1'b1, 8'd0, 8'hE5, 8'd1, 8'd3, 8'd21, 1'b0, 3'd2},
    {1'b1, 8'd2, 8'h05, 8'd1, 8'd3, 8'd33, 1'b0, 3'd2},
    {1'b1, 8'd3, 8'h05, 8'd1, 8'd3, 8'd40, 1'b1, 3'd2},
    {1'b1, 8'd0, 8'h0B, 8'd1, 8'd3, 8'd50, 1'b1, 3'd5},
    {1'b1, 8'd0, 8'h0D, 8'd1, 8'd3, 8'd60, 1'b1, 3'd6}
  };
  localparam string TAGS [8] = '{"R3", "R5", "R5", "R7", "R8", "R9", "R7", "R7"};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           dir_wr = 1'b0;
  logic [AW-1:0]  blk_num = '0;
  logic           blk_mode = 1'b0;
  logic [LW-1:0]  hunt_limit = LW'(4);
  logic [LW-1:0]  busy_limit = LW'(4);
  logic [AW-1:0]  cmd_arg;
  logic           cs_n, sclk, mosi, miso;
  logic [8:0]     buf_addr;
  logic           buf_we;
  logic [7:0]     buf_wdata;
  logic [7:0]     buf_rdata = 8'h00;
  logic           done, err;
  logic [2:0]     wr_status;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  sd_blk_xfer #(.BLK_BYTES(BLK), .HALF_DIV(1), .LIM_W(LW), .ARG_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .blk_num(blk_num), .blk_mode(blk_mode),
    .hunt_limit(hunt_limit), .busy_limit(busy_limit), .cmd_arg(cmd_arg),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .done(done), .err(err), .wr_status(wr_status)
  );

  // local buffer
  logic [7:0] mem [BLK];
  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    buf_rdata <= mem[buf_addr];
  end

  // card model
  logic       card_wr = 1'b0;
  int         card_a = 0;
  logic [7:0] card_tok = 8'h05;
  logic [7:0] card_seed = 8'h00;
  logic [7:0] c_out = 8'hFF;
  logic [7:0] c_rx = 8'h00;
  logic [7:0] h_rx = 8'h00;
  logic [7:0] h_last = 8'h00;
  int         c_bits = 0, c_k = 0, h_bits = 0, h_cnt = 0;
  logic [7:0] cap [CAPN];

  function automatic logic [7:0] rpat(int i, logic [7:0] s);
    return 8'(i * 7) ^ s;
  endfunction

  function automatic logic [7:0] wpat(int i, logic [7:0] s);
    return 8'(i * 5) + s;
  endfunction

  function automatic logic [7:0] resp(int k);
    if (!card_wr) begin
      if (k < card_a) return (k % 2 == 1) ? 8'h3C : 8'hFF;
      if (k == card_a) return 8'hFE;
      if (k <= card_a + BLK) return rpat(k - card_a - 1, card_seed);
      if (k == card_a + BLK + 1) return 8'hAB;
      if (k == card_a + BLK + 2) return 8'hCD;
      return 8'hFF;
    end else begin
      if (k < BLK + 3) return 8'hFF;
      if (k == BLK + 3) return card_tok;
      if (k < BLK + 4 + card_a) return 8'h00;
      return 8'hFF;
    end
  endfunction

  assign miso = cs_n ? 1'b1 : c_out[7];

  always @(negedge cs_n) begin
    c_k    = 0;
    c_bits = 0;
    h_bits = 0;
    h_cnt  = 0;
    c_out  = resp(0);
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      c_rx = {c_rx[6:0], mosi};
      c_bits = c_bits + 1;
      if (c_bits == 8) begin
        c_bits = 0;
        if (c_k < CAPN) cap[c_k] = c_rx;
        c_k = c_k + 1;
        c_out = resp(c_k);
      end
    end else begin
      h_rx = {h_rx[6:0], mosi};
      h_bits = h_bits + 1;
      if (h_bits == 8) begin
        h_bits = 0;
        h_cnt = h_cnt + 1;
        h_last = h_rx;
      end
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && c_bits != 0) c_out = {c_out[6:0], 1'b1};
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic dir, input int a, input logic [7:0] tok,
                          input int hlim, input int blim, input logic [7:0] seed,
                          input logic exp_err, input logic [2:0] exp_stat,
                          input string tag, input bit poke);
    int cyc;
    int expb;
    int mis;
    int nonfill;
    card_wr   = dir;
    card_a    = a;
    card_tok  = tok;
    card_seed = seed;
    for (int i = 0; i < BLK; i++) mem[i] = dir ? wpat(i, seed) : 8'h5A;
    hunt_limit = LW'(hlim);
    busy_limit = LW'(blim);
    @(negedge clk);
    dir_wr = dir;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40000) begin
      if (poke && cyc == 300) begin
        start  = 1'b1;
        dir_wr = !dir;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done && cs_n, {tag, " done with cs_n high (R10)"}, {30'd0, done, cs_n}, 32'h3);
    chk(err == exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
    chk(wr_status == exp_stat, {tag, " wr_status"}, 32'(wr_status), 32'(exp_stat));
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 32'd0);
    chk(h_cnt == 1 && h_last == 8'hFF, "R10 one trailing 0xFF byte", 32'(h_cnt), 32'd1);
    if (!dir) expb = exp_err ? hlim : a + BLK + 3;
    else if (exp_stat != 3'd2) expb = BLK + 4;
    else if (exp_err) expb = BLK + 4 + blim;
    else expb = BLK + 5 + a;
    chk(c_k == expb, {tag, dir ? " R8 byte count" : " R4 byte count"}, 32'(c_k), 32'(expb));
    mis = 0;
    if (!dir) begin
      nonfill = 0;
      for (int i = 0; i < BLK; i++) begin
        if (exp_err) begin
          if (mem[i] != 8'h5A) mis++;
        end else if (mem[i] != rpat(i, seed)) mis++;
      end
      for (int i = 0; i < expb; i++) if (cap[i] != 8'hFF) nonfill++;
      chk(mis == 0, exp_err ? "R5 buffer untouched" : "R3 buffer contents", 32'(mis), 32'd0);
      chk(nonfill == 0, "R3 read sends only 0xFF", 32'(nonfill), 32'd0);
    end else begin
      for (int i = 0; i < BLK; i++) if (cap[i + 1] != mem[i]) mis++;
      chk(cap[0] == 8'hFE, "R6 start token sent", 32'(cap[0]), 32'hFE);
      chk(mis == 0, "R6 block bytes sent", 32'(mis), 32'd0);
      chk(cap[BLK + 1] == 8'hFF && cap[BLK + 2] == 8'hFF && cap[BLK + 3] == 8'hFF,
          "R6 dummy checksum bytes", {8'd0, cap[BLK + 1], cap[BLK + 2], cap[BLK + 3]}, 32'hFFFFFF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 32'd1);
    chk(done == 1'b0 && err == 1'b0, "R1 done/err", {30'd0, done, err}, 32'd0);
    chk(wr_status == 3'd0, "R1 wr_status", 32'(wr_status), 32'd0);
    chk(sclk == 1'b0 && mosi == 1'b1, "R1 sclk/mosi", {30'd0, sclk, mosi}, 32'h1);

    // R2 argument conversion
    blk_num = 32'h0012_3456; blk_mode = 1'b0;
    @(negedge clk);
    chk(cmd_arg == 32'h2468_AC00, "R2 byte addressing", cmd_arg, 32'h2468_AC00);
    blk_mode = 1'b1;
    @(negedge clk);
    chk(cmd_arg == 32'h0012_3456, "R2 block addressing", cmd_arg, 32'h0012_3456);
    blk_num = 32'h00FF_FFFF; blk_mode = 1'b0;
    @(negedge clk);
    chk(cmd_arg == 32'hFFFF_FE00, "R2 truncation", cmd_arg, 32'hFFFF_FE00);

    // table walk
    for (int v = 0; v < 8; v++) begin
      run_case(VECS[v][44], int'(VECS[v][43:36]), VECS[v][35:28], int'(VECS[v][27:20]),
               int'(VECS[v][19:12]), VECS[v][11:4], VECS[v][3], VECS[v][2:0], TAGS[v], 1'b0);
    end

    // R11: start pulse with the other direction during a read
    run_case(1'b0, 2, 8'h00, 8, 1, 8'h77, 1'b0, 3'd0, "R11", 1'b1);
    // R8 longer busy run after a token with set upper bits
    run_case(1'b1, 5, 8'hA5, 1, 6, 8'h13, 1'b0, 3'd2, "R8", 1'b0);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule